// File: doc/BRIEF.md
# Integer Compare and Trap Unit

This block evaluates the relation between two 32-bit integer operands for a processor's execute stage. The right-hand operand is either a register value or a 16-bit immediate widened to 32 bits. In compare mode the unit writes a 4-bit condition code that is one-hot and shows less-than, greater-than or equal. The relation is measured as two's-complement or as unsigned, depending on a select input.

In trap mode the unit computes all five relations at once: signed less, signed greater, equal, unsigned less and unsigned greater. It masks them with a 5-bit condition selector and raises a program-trap request when any selected relation is true. A single instruction can therefore trap on a mix of signed and unsigned conditions.

Work is offered with a one-cycle `valid_i` strobe. The results are registered. The condition code holds its value until the next compare, and the trap request is a one-cycle pulse.

Top module: `cmp_trap_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `cc_o` is 4'b0000, and `cc_valid_o` and `trap_o` are 0.
- R2: A compare (`valid_i`=1, `trap_mode_i`=0) updates `cc_o` on the next clock edge. The value is 4'b1000 when A is below the right-hand operand, 4'b0100 when above and 4'b0010 when equal. `cc_valid_o` is 1 for exactly that one cycle.
- R3: With `signed_i`=1, a compare treats both operands as two's-complement numbers.
- R4: With `signed_i`=0, a compare treats both operands as unsigned numbers.
- R5: With `use_imm_i`=1, the right-hand operand is `imm_i`. In a compare it is sign-extended when `signed_i`=1 and zero-extended when `signed_i`=0.
- R6: In a trap (`trap_mode_i`=1), each bit of `tmask_i` selects one relation. Bit 4 selects signed less, bit 3 signed greater, bit 2 equal, bit 1 unsigned less and bit 0 unsigned greater. `trap_o` is 1 on the next cycle when at least one selected relation holds.
- R7: In a trap, `imm_i` is always sign-extended, whatever `signed_i` is. It then takes part in both the signed and the unsigned relations.
- R8: A trap with `tmask_i`=5'b00000 never raises `trap_o`. A trap with `tmask_i`=5'b11111 always raises it.
- R9: `trap_o` is 1 only in the cycle after a trap strobe, and it lasts one cycle. A trap strobe leaves `cc_o` unchanged and does not assert `cc_valid_o`.
- R10: `cc_o` keeps its value in every cycle that does not follow a compare strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_a_i | input | 32 | Left-hand operand |
| op_b_i | input | 32 | Right-hand register operand |
| imm_i | input | 16 | Immediate operand |
| use_imm_i | input | 1 | Use the immediate as the right-hand operand |
| signed_i | input | 1 | Signed compare select; 0 selects logical compare |
| trap_mode_i | input | 1 | 1 selects trap evaluation, 0 selects compare |
| tmask_i | input | 5 | Trap condition selector |
| cc_o | output | 4 | Registered condition code |
| cc_valid_o | output | 1 | Pulse: `cc_o` was just written |
| trap_o | output | 1 | One-cycle program-trap request |

## Verification
The only state in the block is the registered condition code and the two pulse flags. A fault in any of them shows at the ports one cycle after the strobe that set it. A wrong code, a missing or stretched pulse, or a code disturbed by a trap can all be seen at that point.

Faults in the relation logic or in the immediate widening show up as a wrong code or a wrong trap decision in that same cycle. To expose them, the stimulus uses operand pairs whose signed and unsigned order disagree. It also uses immediates whose sign bit is set, so that sign extension and zero extension give different results.

// File: rtl/cmp_trap_pkg.sv
package cmp_trap_pkg;

    localparam int TMASK_W = 5;
    localparam int CC_W    = 4;

    // mask bit positions; the relation struct below uses the same order
    localparam int TB_SLT = 4;
    localparam int TB_SGT = 3;
    localparam int TB_EQ  = 2;
    localparam int TB_ULT = 1;
    localparam int TB_UGT = 0;

    typedef enum logic [CC_W-1:0] {
        CC_NONE = 4'b0000,
        CC_LT   = 4'b1000,
        CC_GT   = 4'b0100,
        CC_EQ   = 4'b0010
    } cc_e;

    // packed MSB first: slt is bit 4 ... ugt is bit 0
    typedef struct packed {
        logic slt;
        logic sgt;
        logic eq;
        logic ult;
        logic ugt;
    } rel_t;

    typedef struct packed {
        cc_e  cc;
        logic cc_vld;
        logic trap;
    } ctu_state_t;

endpackage

// File: rtl/cmp_opsel.sv
module cmp_opsel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              sext,
    output logic [DATA_W-1:0] rhs
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_wide;

    generate
        if (EXT_W > 0) begin : g_extend
            logic fill;
            assign fill     = sext & imm[IMM_W-1];
            assign imm_wide = {{EXT_W{fill}}, imm};
        end else begin : g_trunc
            assign imm_wide = imm[DATA_W-1:0];
        end
    endgenerate

    assign rhs = use_imm ? imm_wide : reg_b;

endmodule

// File: rtl/cmp_relations.sv
module cmp_relations
    import cmp_trap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output rel_t              rel
);
    logic eq_w;
    logic ult_w;
    logic slt_w;

    always_comb begin
        eq_w    = (lhs == rhs);
        ult_w   = (lhs < rhs);
        slt_w   = ($signed(lhs) < $signed(rhs));
        rel.eq  = eq_w;
        rel.ult = ult_w;
        rel.ugt = !ult_w && !eq_w;
        rel.slt = slt_w;
        rel.sgt = !slt_w && !eq_w;
    end

endmodule

// File: rtl/cmp_trap_eval.sv
module cmp_trap_eval
    import cmp_trap_pkg::*;
(
    input  logic [TMASK_W-1:0] mask,
    input  rel_t               rel,
    output logic               hit
);
    logic [TMASK_W-1:0] rel_v;
    logic [TMASK_W-1:0] sel;

    assign rel_v = rel;

    generate
        for (genvar i = 0; i < TMASK_W; i++) begin : g_sel
            assign sel[i] = mask[i] & rel_v[i];
        end
    endgenerate

    assign hit = |sel;

endmodule

// File: rtl/cmp_trap_unit.sv
module cmp_trap_unit
    import cmp_trap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [DATA_W-1:0]  op_a_i,
    input  logic [DATA_W-1:0]  op_b_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic               use_imm_i,
    input  logic               signed_i,
    input  logic               trap_mode_i,
    input  logic [TMASK_W-1:0] tmask_i,
    output logic [CC_W-1:0]    cc_o,
    output logic               cc_valid_o,
    output logic               trap_o
);
    logic [DATA_W-1:0] rhs;
    logic              imm_sext;
    rel_t              rel;
    logic              hit;
    ctu_state_t        st_d;
    ctu_state_t        st_q;

    // a trap immediate is always sign-extended; a compare follows the signedness select
    assign imm_sext = trap_mode_i | signed_i;

    cmp_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .reg_b   (op_b_i),
        .imm     (imm_i),
        .use_imm (use_imm_i),
        .sext    (imm_sext),
        .rhs     (rhs)
    );

    cmp_relations #(.DATA_W(DATA_W)) u_rel (
        .lhs (op_a_i),
        .rhs (rhs),
        .rel (rel)
    );

    cmp_trap_eval u_eval (
        .mask (tmask_i),
        .rel  (rel),
        .hit  (hit)
    );

    always_comb begin
        st_d        = st_q;
        st_d.cc_vld = 1'b0;
        st_d.trap   = 1'b0;
        if (valid_i) begin
            if (trap_mode_i) begin
                st_d.trap = hit;
            end else begin
                st_d.cc_vld = 1'b1;
                if (rel.eq)
                    st_d.cc = CC_EQ;
                else if (signed_i ? rel.slt : rel.ult)
                    st_d.cc = CC_LT;
                else
                    st_d.cc = CC_GT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cc: CC_NONE, cc_vld: 1'b0, trap: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cc_o       = st_q.cc;
    assign cc_valid_o = st_q.cc_vld;
    assign trap_o     = st_q.trap;

    // R2: a freshly written code is one of the three legal one-hot values
    p_cc_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid_o |-> (cc_o == CC_LT || cc_o == CC_GT || cc_o == CC_EQ));

    // R9: a trap request only follows a trap strobe
    p_trap_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(valid_i && trap_mode_i));

    // R9: a trap strobe never produces a code-valid pulse
    p_trap_no_cc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && trap_mode_i) |=> !cc_valid_o);

    // R8: an empty mask never traps
    p_zero_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && trap_mode_i && tmask_i == '0) |=> !trap_o);

    // R8: a full mask always traps
    p_full_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && trap_mode_i && tmask_i == '1) |=> trap_o);

    // R6: an equal pair with the equal bit selected traps
    p_eq_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && trap_mode_i && tmask_i[TB_EQ] && op_a_i == rhs) |=> trap_o);

    // R10: the code is held unless a compare was strobed
    p_cc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && !trap_mode_i) |=> $stable(cc_o));

endmodule

// File: tb/cmp_trap_unit_test.sv
module cmp_trap_unit_test;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic        use_imm;
        logic        sgn;
        logic        trap;
        logic [4:0]  mask;
        logic [3:0]  exp_cc;
        logic        exp_trap;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;

    // exp_cc on trap rows is the code left by the last compare row
    localparam vec_t TBL [0:NV-1] = '{
        '{32'h0000_0005, 32'h0000_0007, 16'h0000, 1'b0, 1'b1, 1'b0, 5'h00, 4'b1000, 1'b0, 4'd2}, // R2 lt
        '{32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0, 1'b1, 1'b0, 5'h00, 4'b1000, 1'b0, 4'd3}, // R3 -1 < 1
        '{32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0, 1'b0, 1'b0, 5'h00, 4'b0100, 1'b0, 4'd4}, // R4 big > 1
        '{32'h0000_1234, 32'h0000_1234, 16'h0000, 1'b0, 1'b1, 1'b0, 5'h00, 4'b0010, 1'b0, 4'd2}, // R2 eq
        '{32'h8000_0000, 32'h7FFF_FFFF, 16'h0000, 1'b0, 1'b1, 1'b0, 5'h00, 4'b1000, 1'b0, 4'd3}, // R3 min < max
        '{32'h8000_0000, 32'h7FFF_FFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 5'h00, 4'b0100, 1'b0, 4'd4}, // R4
        '{32'hFFFF_FFFE, 32'h0000_0000, 16'hFFFF, 1'b1, 1'b1, 1'b0, 5'h00, 4'b1000, 1'b0, 4'd5}, // R5 -2 < -1
        '{32'hFFFF_FFFE, 32'h0000_0000, 16'hFFFF, 1'b1, 1'b0, 1'b0, 5'h00, 4'b0100, 1'b0, 4'd5}, // R5 zero-ext
        '{32'h0000_FFFF, 32'h0000_0000, 16'hFFFF, 1'b1, 1'b0, 1'b0, 5'h00, 4'b0010, 1'b0, 4'd5}, // R5 eq
        '{32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0, 1'b1, 1'b1, 5'h10, 4'b0010, 1'b1, 4'd6}, // R6 slt
        '{32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0, 1'b1, 1'b1, 5'h02, 4'b0010, 1'b0, 4'd6}, // R6 ult
        '{32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0, 1'b1, 1'b1, 5'h01, 4'b0010, 1'b1, 4'd6}, // R6 ugt
        '{32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0, 1'b1, 1'b1, 5'h08, 4'b0010, 1'b0, 4'd6}, // R6 sgt
        '{32'h0000_0005, 32'h0000_0005, 16'h0000, 1'b0, 1'b1, 1'b1, 5'h04, 4'b0010, 1'b1, 4'd6}, // R6 eq
        '{32'h0000_0005, 32'h0000_0005, 16'h0000, 1'b0, 1'b1, 1'b1, 5'h1B, 4'b0010, 1'b0, 4'd6}, // R6 all but eq
        '{32'h0000_0001, 32'h0000_0002, 16'h0000, 1'b0, 1'b1, 1'b1, 5'h00, 4'b0010, 1'b0, 4'd8}, // R8 empty
        '{32'h0000_0003, 32'h0000_0003, 16'h0000, 1'b0, 1'b1, 1'b1, 5'h1F, 4'b0010, 1'b1, 4'd8}, // R8 full
        '{32'h0000_0000, 32'h8000_0000, 16'h0000, 1'b0, 1'b0, 1'b1, 5'h1F, 4'b0010, 1'b1, 4'd8}, // R8 full
        '{32'hFFFF_FFF0, 32'h0000_0000, 16'h8000, 1'b1, 1'b1, 1'b1, 5'h02, 4'b0010, 1'b0, 4'd7}, // R7 ult false
        '{32'hFFFF_FFF0, 32'h0000_0000, 16'h8000, 1'b1, 1'b1, 1'b1, 5'h01, 4'b0010, 1'b1, 4'd7}, // R7 ugt
        '{32'h0001_0000, 32'h0000_0000, 16'hFFFF, 1'b1, 1'b0, 1'b1, 5'h02, 4'b0010, 1'b1, 4'd7}, // R7 sext with logical
        '{32'h0000_0005, 32'h0000_0000, 16'h8000, 1'b1, 1'b1, 1'b1, 5'h12, 4'b0010, 1'b1, 4'd7}  // R7 ult only
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic [15:0] imm_i = '0;
    logic        use_imm_i = 1'b0;
    logic        signed_i = 1'b0;
    logic        trap_mode_i = 1'b0;
    logic [4:0]  tmask_i = '0;
    logic [3:0]  cc_o;
    logic        cc_valid_o;
    logic        trap_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cmp_trap_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid_i),
        .op_a_i      (op_a_i),
        .op_b_i      (op_b_i),
        .imm_i       (imm_i),
        .use_imm_i   (use_imm_i),
        .signed_i    (signed_i),
        .trap_mode_i (trap_mode_i),
        .tmask_i     (tmask_i),
        .cc_o        (cc_o),
        .cc_valid_o  (cc_valid_o),
        .trap_o      (trap_o)
    );

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_a_i      = v.a;
        op_b_i      = v.b;
        imm_i       = v.imm;
        use_imm_i   = v.use_imm;
        signed_i    = v.sgn;
        trap_mode_i = v.trap;
        tmask_i     = v.mask;
        valid_i     = 1'b1;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "cc in reset", 32'(cc_o), 32'h0);
        chk("R1", "trap in reset", 32'(trap_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cc after reset", 32'(cc_o), 32'h0);
        chk("R1", "cc_valid after reset", 32'(cc_valid_o), 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            valid_i = 1'b0;
            chk(req_name(TBL[i].req), $sformatf("cc vec %0d", i), 32'(cc_o), 32'(TBL[i].exp_cc));
            chk(req_name(TBL[i].req), $sformatf("trap vec %0d", i), 32'(trap_o), 32'(TBL[i].exp_trap));
            // R9: trap rows give no code pulse; compare rows do
            chk("R9", $sformatf("cc_valid vec %0d", i), 32'(cc_valid_o), 32'(!TBL[i].trap));
            @(negedge clk);
            chk("R9", $sformatf("pulse width vec %0d", i), 32'(trap_o), 32'h0);
            chk("R2", $sformatf("cc_valid width vec %0d", i), 32'(cc_valid_o), 32'h0);
        end

        // R9/R10: no strobe with a full mask raises nothing and holds the code
        trap_mode_i = 1'b1;
        tmask_i     = 5'h1F;
        op_a_i      = 32'h1;
        op_b_i      = 32'h9;
        use_imm_i   = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R9", "no trap without strobe", 32'(trap_o), 32'h0);
            chk("R10", "cc held without strobe", 32'(cc_o), 32'b0010);
        end

        // R9: back-to-back trap strobes, code unchanged throughout
        valid_i = 1'b1;
        @(negedge clk);
        chk("R9", "first back-to-back trap", 32'(trap_o), 32'h1);
        @(negedge clk);
        valid_i = 1'b0;
        chk("R9", "second back-to-back trap", 32'(trap_o), 32'h1);
        chk("R9", "cc untouched by traps", 32'(cc_o), 32'b0010);
        @(negedge clk);
        chk("R9", "trap drops after last strobe", 32'(trap_o), 32'h0);

        // R10: a new compare replaces the held code, then it holds again
        trap_mode_i = 1'b0;
        signed_i    = 1'b0;
        valid_i     = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        chk("R10", "cc after compare", 32'(cc_o), 32'b1000);
        repeat (2) @(negedge clk);
        chk("R10", "cc held later", 32'(cc_o), 32'b1000);

        // R1: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "cc cleared by reset", 32'(cc_o), 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule